// File: doc/BRIEF.md
# Tagged Operand Store Realization Unit

This unit is the point where a tagged operand leaves the core and becomes plain memory contents. A store request brings one operand together with a byte address. The operand carries a payload of up to four lanes. Its tag holds a size code, a scalar or vector flag, one validity bit per lane, and five floating-point status flags. The unit turns this into a single byte-enabled write request and removes every tag bit. The number of bytes written comes from the operand's own size code, not from the instruction.

The unit also screens the lanes. An invalid lane whose payload is zero within its element width is an empty value, and it is skipped without writing. An invalid lane with any nonzero byte within its width is a poisoned value. That lane turns the whole request into a fault report instead of a write.

The operand's floating-point flags are held back until this point. On every request that is not faulted, they are ORed into a sticky global status register. An interrupt request pulses when a flag that the mask lets through changes from 0 to 1. All outputs are registered and appear one clock after the request.

Top module: `stw_store_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero: no write, no fault, status 0, no interrupt.
- R2: The size code selects 2^code bytes: code 0 gives 1 byte, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 16. A valid scalar request produces a write one cycle later. Its address equals the request address, and bytes 0 to n-1 of the bus carry the low n bytes of lane 0, with their enables set.
- R3: A vector request packs lane i, element width n bytes, into bus bytes i*n to i*n+n-1, lane 0 lowest.
- R4: A lane that is invalid and zero within its width gets its byte enables cleared. A request in which every considered lane is like this produces no write.
- R5: If any considered lane is invalid and nonzero within its width, the request produces a fault pulse and no write. The fault lane output gives the lowest such lane index.
- R6: Only value bytes reach the bus. Bytes without an enable, and the whole bus when no write is issued, are driven as zero.
- R7: The status register is sticky: each non-faulted request ORs its flags into it. The bit positions are 0 divide-by-zero, 1 inexact, 2 invalid, 3 underflow, 4 overflow.
- R8: The clear input zeroes the status register. Flags from a request in the same cycle are applied after the clear and remain set.
- R9: The interrupt output is high for exactly the cycle in which at least one status bit whose mask bit is 1 changes from 0 to 1.
- R10: A faulted request leaves the status register unchanged.
- R11: Payload bytes of an invalid lane above its element width do not affect the empty or poisoned decision. For a scalar, lanes 1 to 3 are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present this cycle |
| req_addr | input | ADDR_W | Base byte address |
| req_size | input | 3 | Element size code, 2^code bytes |
| req_vector | input | 1 | 1: four-lane vector, 0: scalar in lane 0 |
| req_lane_ok | input | LANES | Per-lane validity, 1 = valid |
| req_payload | input | LANES*LANE_BYTES*8 | Lane i at bits [i*LANE_BYTES*8 +: LANE_BYTES*8] |
| req_flags | input | 5 | Operand floating-point flags |
| flag_clear | input | 1 | Clear the global status register |
| irq_mask | input | 5 | Per-flag interrupt enable |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write base address |
| wr_data | output | LANES*LANE_BYTES*8 | Write bytes, untagged |
| wr_be | output | LANES*LANE_BYTES | Byte enables |
| fault_valid | output | 1 | Poisoned-operand fault pulse |
| fault_lane | output | 2 | Lowest poisoned lane index |
| fpstat | output | 5 | Global sticky status flags |
| irq | output | 1 | Interrupt request pulse |

## Verification
The properties assume that the size code stays within 0 to 4 and that every input is driven to a known level from time zero. They also assume that the mask and clear inputs change only between clock edges. The stimulus uses only legal size codes and changes all inputs just after the falling edge. It also holds the request inputs idle during reset, so that each property sees a defined past. Random operands draw validity bits and zero or nonzero lane payloads, so that empty, poisoned and valid lanes all occur within those legal sizes.

// File: rtl/stw_pkg.sv
package stw_pkg;
    localparam int FLAG_N     = 5;
    localparam int FL_DIVZ    = 0;
    localparam int FL_INEXACT = 1;
    localparam int FL_INVALID = 2;
    localparam int FL_UNDER   = 3;
    localparam int FL_OVER    = 4;
    localparam int SIZE_MAX   = 4;

    typedef logic [FLAG_N-1:0] fpflags_t;

    // element width in bytes for a size code; codes past the largest clamp to it
    function automatic int size_bytes(input logic [2:0] code);
        if (int'(code) > SIZE_MAX)
            return 1 << SIZE_MAX;
        return 1 << int'(code);
    endfunction
endpackage

// File: rtl/stw_lane_screen.sv
module stw_lane_screen #(
    parameter int LANE_BYTES = 16
) (
    input  logic [LANE_BYTES*8-1:0] payload_i,
    input  logic                    ok_i,
    input  logic [2:0]              size_i,
    output logic                    empty_o,
    output logic                    poison_o
);
    import stw_pkg::*;

    logic nonzero;

    // only bytes inside the element width take part
    always_comb begin
        int nb;
        nb      = size_bytes(size_i);
        nonzero = 1'b0;
        for (int b = 0; b < LANE_BYTES; b++) begin
            if (b < nb)
                nonzero = nonzero | (|payload_i[b*8 +: 8]);
        end
    end

    assign empty_o  = !ok_i && !nonzero;
    assign poison_o = !ok_i &&  nonzero;
endmodule

// File: rtl/stw_packer.sv
module stw_packer #(
    parameter int LANES      = 4,
    parameter int LANE_BYTES = 16,
    localparam int OUT_BYTES = LANES * LANE_BYTES
) (
    input  logic [OUT_BYTES*8-1:0] payload_i,
    input  logic [LANES-1:0]       lane_use_i,
    input  logic [2:0]             size_i,
    output logic [OUT_BYTES*8-1:0] data_o,
    output logic [OUT_BYTES-1:0]   be_o
);
    import stw_pkg::*;

    // lane i element lands at byte i*n; unused bytes stay zero
    always_comb begin
        int nb;
        nb     = size_bytes(size_i);
        data_o = '0;
        be_o   = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int b = 0; b < LANE_BYTES; b++) begin
                if (lane_use_i[i] && (b < nb)) begin
                    data_o[(i*nb + b)*8 +: 8] = payload_i[(i*LANE_BYTES + b)*8 +: 8];
                    be_o[i*nb + b]            = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stw_flag_acc.sv
module stw_flag_acc #(
    parameter int FLAGS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fold_i,
    input  logic [FLAGS-1:0] flags_i,
    input  logic             clear_i,
    input  logic [FLAGS-1:0] mask_i,
    output logic [FLAGS-1:0] stat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [FLAGS-1:0] stat;
        logic             irq;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        logic [FLAGS-1:0] base;
        base       = clear_i ? '0 : acc_q.stat;
        acc_d.stat = base | (fold_i ? flags_i : '0);
        acc_d.irq  = |(acc_d.stat & ~acc_q.stat & mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign stat_o = acc_q.stat;
    assign irq_o  = acc_q.irq;
endmodule

// File: rtl/stw_store_unit.sv
module stw_store_unit #(
    parameter int ADDR_W     = 32,
    parameter int LANES      = 4,
    parameter int LANE_BYTES = 16,
    localparam int OUT_BYTES = LANES * LANE_BYTES,
    localparam int LIDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2:0]              req_size,
    input  logic                    req_vector,
    input  logic [LANES-1:0]        req_lane_ok,
    input  logic [OUT_BYTES*8-1:0]  req_payload,
    input  logic [4:0]              req_flags,
    input  logic                    flag_clear,
    input  logic [4:0]              irq_mask,
    output logic                    wr_valid,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [OUT_BYTES*8-1:0]  wr_data,
    output logic [OUT_BYTES-1:0]    wr_be,
    output logic                    fault_valid,
    output logic [LIDX_W-1:0]       fault_lane,
    output logic [4:0]              fpstat,
    output logic                    irq
);
    import stw_pkg::*;

    typedef struct packed {
        logic                   wr;
        logic [ADDR_W-1:0]      addr;
        logic [OUT_BYTES*8-1:0] data;
        logic [OUT_BYTES-1:0]   be;
        logic                   fault;
        logic [LIDX_W-1:0]      lane;
    } out_t;

    logic [LANES-1:0]       lane_active;
    logic [LANES-1:0]       lane_empty;
    logic [LANES-1:0]       lane_poison;
    logic [LANES-1:0]       lane_use;
    logic [OUT_BYTES*8-1:0] packed_data;
    logic [OUT_BYTES-1:0]   packed_be;
    logic                   any_poison;
    logic                   fold;

    // a scalar only looks at lane 0
    always_comb begin
        lane_active    = req_vector ? '1 : '0;
        lane_active[0] = 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        stw_lane_screen #(.LANE_BYTES(LANE_BYTES)) u_screen (
            .payload_i (req_payload[g*LANE_BYTES*8 +: LANE_BYTES*8]),
            .ok_i      (req_lane_ok[g]),
            .size_i    (req_size),
            .empty_o   (lane_empty[g]),
            .poison_o  (lane_poison[g])
        );
    end

    assign lane_use   = lane_active & req_lane_ok;
    assign any_poison = |(lane_poison & lane_active);
    assign fold       = req_valid && !any_poison;

    stw_packer #(.LANES(LANES), .LANE_BYTES(LANE_BYTES)) u_pack (
        .payload_i  (req_payload),
        .lane_use_i (lane_use),
        .size_i     (req_size),
        .data_o     (packed_data),
        .be_o       (packed_be)
    );

    stw_flag_acc #(.FLAGS(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .fold_i  (fold),
        .flags_i (req_flags),
        .clear_i (flag_clear),
        .mask_i  (irq_mask),
        .stat_o  (fpstat),
        .irq_o   (irq)
    );

    out_t out_d, out_q;

    always_comb begin
        logic [LIDX_W-1:0] first;
        logic              do_wr;
        first = '0;
        for (int i = LANES-1; i >= 0; i--) begin
            if (lane_poison[i] && lane_active[i])
                first = LIDX_W'(i);
        end
        do_wr       = fold && (|packed_be);
        out_d.wr    = do_wr;
        out_d.addr  = do_wr ? req_addr : '0;
        out_d.data  = do_wr ? packed_data : '0;
        out_d.be    = do_wr ? packed_be : '0;
        out_d.fault = req_valid && any_poison;
        out_d.lane  = (req_valid && any_poison) ? first : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign wr_valid    = out_q.wr;
    assign wr_addr     = out_q.addr;
    assign wr_data     = out_q.data;
    assign wr_be       = out_q.be;
    assign fault_valid = out_q.fault;
    assign fault_lane  = out_q.lane;

    logic unused_ok;
    assign unused_ok = ^lane_empty;
endmodule

// File: rtl/stw_store_chk.sv
module stw_store_chk #(
    parameter int ADDR_W     = 32,
    parameter int LANES      = 4,
    parameter int LANE_BYTES = 16,
    localparam int OUT_BYTES = LANES * LANE_BYTES,
    localparam int LIDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_vector,
    input logic                   flag_clear,
    input logic [4:0]             irq_mask,
    input logic                   wr_valid,
    input logic [OUT_BYTES-1:0]   wr_be,
    input logic                   fault_valid,
    input logic [4:0]             fpstat,
    input logic                   irq
);
    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && fault_valid));

    p_write_has_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != '0));

    p_out_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || fault_valid) |-> $past(req_valid));

    p_scalar_low_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !$past(req_vector)) |-> (wr_be[OUT_BYTES-1:LANE_BYTES] == '0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flag_clear) |-> ((fpstat & $past(fpstat)) == $past(fpstat)));

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((fpstat & ~$past(fpstat) & $past(irq_mask)) != 5'd0));

    p_fault_keeps_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !$past(flag_clear)) |-> $stable(fpstat));
endmodule

bind stw_store_unit stw_store_chk #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_BYTES(LANE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .flag_clear(flag_clear), .irq_mask(irq_mask), .wr_valid(wr_valid),
    .wr_be(wr_be), .fault_valid(fault_valid), .fpstat(fpstat), .irq(irq)
);

// File: tb/sim_stw_store_unit.sv
`timescale 1ns/1ps
module sim_stw_store_unit;
    localparam int AW = 32;
    localparam int NL = 4;
    localparam int LB = 16;
    localparam int OB = NL * LB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [2:0]        req_size = '0;
    logic              req_vector = 1'b0;
    logic [NL-1:0]     req_lane_ok = '0;
    logic [OB*8-1:0]   req_payload = '0;
    logic [4:0]        req_flags = '0;
    logic              flag_clear = 1'b0;
    logic [4:0]        irq_mask = '0;
    logic              wr_valid;
    logic [AW-1:0]     wr_addr;
    logic [OB*8-1:0]   wr_data;
    logic [OB-1:0]     wr_be;
    logic              fault_valid;
    logic [1:0]        fault_lane;
    logic [4:0]        fpstat;
    logic              irq;

    always #2 clk = ~clk;

    stw_store_unit #(.ADDR_W(AW), .LANES(NL), .LANE_BYTES(LB)) u0 (.*);

    int vectors = 0;
    int misses  = 0;
    string tag = "R1";
    bit done = 0;

    logic [4:0]      m_stat = '0;
    logic            e_wr = 0, e_fault = 0, e_irq = 0;
    logic [AW-1:0]   e_addr = '0;
    logic [OB*8-1:0] e_data = '0;
    logic [OB-1:0]   e_be = '0;
    logic [1:0]      e_lane = '0;

    function automatic logic [OB*8-1:0] rnd_payload();
        logic [OB*8-1:0] p;
        for (int w = 0; w < OB/4; w++) p[w*32 +: 32] = $urandom;
        return p;
    endfunction

    task automatic miss(string what, logic [511:0] act, logic [511:0] exp);
        misses++;
        $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic compare();
        vectors++;
        if (wr_valid !== e_wr)       miss("wr_valid", 512'(wr_valid), 512'(e_wr));
        if (wr_addr !== e_addr)      miss("wr_addr", 512'(wr_addr), 512'(e_addr));
        if (wr_data !== e_data)      miss("wr_data", wr_data, e_data);
        if (wr_be !== e_be)          miss("wr_be", 512'(wr_be), 512'(e_be));
        if (fault_valid !== e_fault) miss("fault_valid", 512'(fault_valid), 512'(e_fault));
        if (fault_lane !== e_lane)   miss("fault_lane", 512'(fault_lane), 512'(e_lane));
        if (fpstat !== m_stat)       miss("fpstat R7", 512'(fpstat), 512'(m_stat));
        if (irq !== e_irq)           miss("irq R9", 512'(irq), 512'(e_irq));
    endtask

    // behavioural expectation for the next clock, from the written requirements
    task automatic predict();
        int n, nl;
        bit pois;
        logic [4:0] nxt;
        n = 1 << req_size;
        nl = req_vector ? NL : 1;
        pois = 0;
        e_lane = '0;
        e_data = '0;
        e_be = '0;
        if (req_valid) begin
            for (int l = nl - 1; l >= 0; l--) begin
                bit nz = 0;
                for (int k = 0; k < n; k++)
                    if (req_payload[l*LB*8 + k*8 +: 8] != 8'h00) nz = 1;
                if (!req_lane_ok[l] && nz) begin
                    pois = 1;
                    e_lane = 2'(l);
                end
            end
            if (!pois)
                for (int l = 0; l < nl; l++)
                    if (req_lane_ok[l])
                        for (int k = 0; k < n; k++) begin
                            e_data[(l*n + k)*8 +: 8] = req_payload[l*LB*8 + k*8 +: 8];
                            e_be[l*n + k] = 1'b1;
                        end
        end
        e_fault = req_valid && pois;
        e_wr = req_valid && !pois && (e_be != '0);
        if (!e_wr) begin e_data = '0; e_be = '0; end
        e_addr = e_wr ? req_addr : '0;
        nxt = (flag_clear ? 5'd0 : m_stat) | ((req_valid && !pois) ? req_flags : 5'd0);
        e_irq = |(nxt & ~m_stat & irq_mask);
        m_stat = nxt;
    endtask

    task automatic tick();
        predict();
        @(negedge clk);
        compare();
        req_valid = 0;
        flag_clear = 0;
        req_flags = '0;
    endtask

    task automatic store(logic [2:0] sz, logic vec, logic [3:0] ok,
                         logic [OB*8-1:0] pl, logic [4:0] fl);
        req_valid = 1;
        req_addr = $urandom;
        req_size = sz;
        req_vector = vec;
        req_lane_ok = ok;
        req_payload = pl;
        req_flags = fl;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [OB*8-1:0] p;
        // R1: outputs during and right after reset
        tag = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1;
        tick();

        // R2 / R6: every scalar size, upper lanes full of junk
        tag = "R2";
        for (int s = 0; s <= 4; s++) store(3'(s), 0, 4'b0001, rnd_payload(), 5'd0);
        tag = "R6";
        store(3'd0, 0, 4'b1111, rnd_payload(), 5'd0);

        // R3: vector packing at every size
        tag = "R3";
        for (int s = 0; s <= 4; s++) store(3'(s), 1, 4'b1111, rnd_payload(), 5'd0);

        // R4: empty lanes 1 and 3, then all empty, then scalar empty
        tag = "R4";
        p = rnd_payload();
        p[1*LB*8 +: LB*8] = '0;
        p[3*LB*8 +: LB*8] = '0;
        store(3'd2, 1, 4'b0101, p, 5'd0);
        store(3'd3, 1, 4'b0000, '0, 5'd0);
        store(3'd4, 0, 4'b0000, '0, 5'd0);

        // R5: poisoned lanes 2 and 3, lowest reported
        tag = "R5";
        p = rnd_payload();
        p[2*LB*8 +: 8] = 8'h5a;
        p[3*LB*8 +: 8] = 8'h11;
        store(3'd1, 1, 4'b0011, p, 5'd0);
        // R10: poisoned scalar with flags set does not fold
        tag = "R10";
        irq_mask = 5'h1f;
        p = '0; p[7:0] = 8'h80;
        store(3'd0, 0, 4'b0000, p, 5'h1f);

        // R11: nonzero only above width is still empty; scalar ignores lane 1
        tag = "R11";
        p = '0; p[5*8 +: 8] = 8'hff;
        store(3'd0, 1, 4'b1110, p, 5'd0);
        p = rnd_payload(); p[LB*8-1:0] = rnd_payload();
        store(3'd2, 0, 4'b0001, p, 5'd0);

        // R7 / R9: sticky OR with edge interrupt
        tag = "R9";
        store(3'd0, 0, 4'b0001, rnd_payload(), 5'b00010);
        store(3'd0, 0, 4'b0001, rnd_payload(), 5'b00010);
        tag = "R7";
        store(3'd0, 0, 4'b0001, rnd_payload(), 5'b00101);
        tick();
        tag = "R9";
        irq_mask = 5'b00000;
        store(3'd0, 0, 4'b0001, rnd_payload(), 5'b10000);

        // R8: clear alone, then clear with same-cycle flags
        tag = "R8";
        irq_mask = 5'h1f;
        flag_clear = 1; tick();
        flag_clear = 1; store(3'd1, 0, 4'b0001, rnd_payload(), 5'b01000);
        tick();

        // mixed random traffic
        tag = "R3";
        for (int it = 0; it < 300; it++) begin
            logic [3:0] ok;
            ok = 4'($urandom);
            p = rnd_payload();
            for (int l = 0; l < NL; l++)
                if (!ok[l] && ($urandom % 2 == 0)) p[l*LB*8 +: LB*8] = '0;
            irq_mask = 5'($urandom);
            flag_clear = ($urandom % 8 == 0);
            if ($urandom % 4 == 0) tick();
            else store(3'($urandom % 5), 1'($urandom), ok, p, 5'($urandom % 3 == 0 ? $urandom : 0));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule